// File: doc/BRIEF.md
# Four-State Power Mode Controller

This block steps a small processor core through four power modes: running, standby, sleep and deep sleep. Software picks a mode by writing a 2-bit code with a write strobe. The block then holds the core clock enable, the peripheral power enable, and the power-keep enables for internal RAM and for each external RAM bank at the values that mode calls for. It watches the interrupt lines and a dedicated active-low wake pin, and it decides when to leave the mode.

Standby ends quietly, and the core picks up where it stopped. Sleep and deep sleep end with a core reset pulse, so the program restarts from address 0x0000. A cause code records why the last core reset happened. Power switches and clock gates are outside the block; it only drives their enable lines. Wake sources such as pin edge detectors are outside the block too, and all inputs are assumed to be synchronous to `clk`.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A write (`mode_wr` high) while running takes effect on the next clock edge. The code means 00 running, 01 standby, 10 sleep, 11 deep sleep. `mode_rd` shows the active code, and a write of 00 leaves the block running.
- R2: In standby, `core_clk_en` is 0, and peripherals, internal RAM and all banks stay on. The first cycle in which any line has both `irq_pend` and `irq_en` high returns the block to running on the next edge, with no core reset.
- R3: In sleep, `core_clk_en` and `periph_on` are 0 and `iram_on` is 1. Each `bank_on[i]` equals `bank_keep[i]` as sampled with the write that entered sleep.
- R4: Only a line that is pending, enabled and set in parameter `SLP_WAKE_MASK` (default lines 0 to 3) ends sleep. Any other interrupt leaves the block in sleep.
- R5: In deep sleep, `core_clk_en`, `periph_on`, `iram_on` and every `bank_on` are 0. Interrupts are ignored, and only `wake_pin_n` low ends the mode.
- R6: Waking from sleep or deep sleep drives `core_rst` high for exactly `RST_CYC` cycles (default 4, at least 4), with clocks, peripherals and RAM on. The block then runs with `mode_rd` = 00.
- R7: `rst_cause` is 00 for the power-on/pin reset (`rst_n`), 01 for a wake from sleep or deep sleep, 10 for watchdog and 11 for software. It changes only when a core reset starts.
- R8: While running, `wdt_rst` or `sw_rst` starts a core reset of `RST_CYC` cycles. Watchdog wins over software, and either one wins over a mode write in the same cycle.
- R9: Mode writes, `wdt_rst` and `sw_rst` are ignored outside the running state.
- R10: After `rst_n` is released, `core_rst` stays high for `RST_CYC` cycles with cause 00 and `mode_rd` = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low power-on/pin reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Requested mode code |
| bank_keep | input | NBANK | Per-bank keep-in-sleep bits, sampled with the write |
| irq_pend | input | NIRQ | Interrupt pending lines |
| irq_en | input | NIRQ | Interrupt enable lines |
| wake_pin_n | input | 1 | Dedicated deep-sleep wake pin, active low |
| wdt_rst | input | 1 | Watchdog reset request |
| sw_rst | input | 1 | Software reset request |
| mode_rd | output | 2 | Active mode code |
| core_clk_en | output | 1 | Core clock enable |
| core_rst | output | 1 | Core reset, active high |
| periph_on | output | 1 | Peripheral power enable |
| iram_on | output | 1 | Internal RAM power enable |
| bank_on | output | NBANK | External RAM bank power/keep enables |
| rst_cause | output | 2 | Cause code of the last core reset |

## Verification
A mode write and a watchdog or software reset request can arrive in the same running cycle. The bench drives the watchdog, software and mode-write strobes together, and then software with a mode write. The reference model picks the winner from the priority rule in R8. It expects a reset pulse with cause 10 or 11 and no mode change. Every cycle, the model's expected mode, enables, reset and cause are compared with the outputs.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
// Assumes: state and cause encodings are private to the block, except the
// cause code, which leaves the block unchanged on rst_cause.
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_STBY = 3'd1,
        ST_SLP  = 3'd2,
        ST_DSLP = 3'd3,
        ST_RST  = 3'd4
    } pmc_state_t;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'b00,
        CAUSE_WAKE = 2'b01,
        CAUSE_WDT  = 2'b10,
        CAUSE_SW   = 2'b11
    } pmc_cause_t;

    localparam logic [1:0] MODE_RUN  = 2'b00;
    localparam logic [1:0] MODE_STBY = 2'b01;
    localparam logic [1:0] MODE_SLP  = 2'b10;
    localparam logic [1:0] MODE_DSLP = 2'b11;

endpackage

// File: rtl/pmc_wake_eval.sv
// Wake evaluation: decides, for the current low-power state, whether the
// wake inputs end it and whether that exit needs a core reset.
// Assumes: all inputs are synchronous to the controller clock.
module pmc_wake_eval
    import pmc_pkg::*;
#(
    parameter int                NIRQ          = 8,
    parameter logic [NIRQ-1:0]   SLP_WAKE_MASK = 8'h0F
) (
    input  pmc_state_t      state,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            wake_pin_n,
    output logic            resume,
    output logic            reboot
);

    logic [NIRQ-1:0] live_irq;
    logic            any_irq;
    logic            slp_irq;

    // Purpose: reduce the interrupt lines to "any enabled" and "sleep-capable".
    always_comb begin
        live_irq = irq_pend & irq_en;
        any_irq  = |live_irq;
        slp_irq  = |(live_irq & SLP_WAKE_MASK);
    end

    // Purpose: apply the wake rule that belongs to each mode.
    always_comb begin
        resume = 1'b0;
        reboot = 1'b0;
        unique case (state)
            ST_STBY: resume = any_irq;
            ST_SLP:  reboot = slp_irq;
            ST_DSLP: reboot = ~wake_pin_n;
            default: begin
                resume = 1'b0;
                reboot = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pmc_rst_timer.sv
// Core reset pulse timer: counts cycles spent in the reset state and flags
// the last one, so the pulse lasts exactly RST_CYC cycles.
// Assumes: in_rst stays high from the first to the last reset cycle.
module pmc_rst_timer #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_rst,
    output logic done
);

    localparam int            CW   = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: count reset cycles; clear whenever the reset state is left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_rst && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Purpose: signal the final cycle of the pulse.
    always_comb done = in_rst && (cnt_q == LAST);

endmodule

// File: rtl/pmc_out_dec.sv
// Output decode: turns the controller state and the latched bank-keep bits
// into the mode code, clock, reset and power enables (Moore outputs).
// Assumes: the reset state powers everything so the core can restart.
module pmc_out_dec
    import pmc_pkg::*;
#(
    parameter int NBANK = 2
) (
    input  pmc_state_t       state,
    input  logic [NBANK-1:0] keep_q,
    output logic [1:0]       mode_rd,
    output logic             core_clk_en,
    output logic             core_rst,
    output logic             periph_on,
    output logic             iram_on,
    output logic [NBANK-1:0] bank_on
);

    // Purpose: global enables and visible mode code for each state.
    always_comb begin
        unique case (state)
            ST_STBY: mode_rd = MODE_STBY;
            ST_SLP:  mode_rd = MODE_SLP;
            ST_DSLP: mode_rd = MODE_DSLP;
            default: mode_rd = MODE_RUN;
        endcase
        core_clk_en = (state == ST_RUN) || (state == ST_RST);
        core_rst    = (state == ST_RST);
        periph_on   = (state == ST_RUN) || (state == ST_RST) || (state == ST_STBY);
        iram_on     = (state != ST_DSLP);
    end

    // Purpose: one enable per external RAM bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb begin
            if (state == ST_SLP) begin
                bank_on[b] = keep_q[b];
            end else begin
                bank_on[b] = (state != ST_DSLP);
            end
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode controller top: holds the mode state, the bank-keep bits and
// the reset cause, and combines the wake evaluator, reset timer and output
// decoder.
// Assumes: inputs synchronous to clk; rst_n is the power-on/pin reset.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int                NIRQ          = 8,
    parameter int                NBANK         = 2,
    parameter int                RST_CYC       = 4,
    parameter logic [NIRQ-1:0]   SLP_WAKE_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic [NBANK-1:0] bank_keep,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic             wake_pin_n,
    input  logic             wdt_rst,
    input  logic             sw_rst,
    output logic [1:0]       mode_rd,
    output logic             core_clk_en,
    output logic             core_rst,
    output logic             periph_on,
    output logic             iram_on,
    output logic [NBANK-1:0] bank_on,
    output logic [1:0]       rst_cause
);

    pmc_state_t       state_q, state_d;
    pmc_cause_t       cause_q, cause_d;
    logic [NBANK-1:0] keep_q, keep_d;
    logic             resume, reboot, rst_done;

    pmc_wake_eval #(
        .NIRQ          (NIRQ),
        .SLP_WAKE_MASK (SLP_WAKE_MASK)
    ) u_wake (
        .state      (state_q),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .wake_pin_n (wake_pin_n),
        .resume     (resume),
        .reboot     (reboot)
    );

    pmc_rst_timer #(
        .RST_CYC (RST_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_rst (state_q == ST_RST),
        .done   (rst_done)
    );

    // Purpose: next-state rule; reset requests beat mode writes.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        keep_d  = keep_q;
        unique case (state_q)
            ST_RUN: begin
                if (wdt_rst) begin
                    state_d = ST_RST;
                    cause_d = CAUSE_WDT;
                end else if (sw_rst) begin
                    state_d = ST_RST;
                    cause_d = CAUSE_SW;
                end else if (mode_wr) begin
                    keep_d = bank_keep;
                    unique case (mode_wdata)
                        MODE_STBY: state_d = ST_STBY;
                        MODE_SLP:  state_d = ST_SLP;
                        MODE_DSLP: state_d = ST_DSLP;
                        default:   state_d = ST_RUN;
                    endcase
                end
            end
            ST_STBY: begin
                if (resume) state_d = ST_RUN;
            end
            ST_SLP, ST_DSLP: begin
                if (reboot) begin
                    state_d = ST_RST;
                    cause_d = CAUSE_WAKE;
                end
            end
            ST_RST: begin
                if (rst_done) state_d = ST_RUN;
            end
            default: state_d = ST_RST;
        endcase
    end

    // Purpose: state registers; pin reset starts a power-on reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RST;
            cause_q <= CAUSE_POR;
            keep_q  <= '1;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            keep_q  <= keep_d;
        end
    end

    pmc_out_dec #(
        .NBANK (NBANK)
    ) u_dec (
        .state       (state_q),
        .keep_q      (keep_q),
        .mode_rd     (mode_rd),
        .core_clk_en (core_clk_en),
        .core_rst    (core_rst),
        .periph_on   (periph_on),
        .iram_on     (iram_on),
        .bank_on     (bank_on)
    );

    // Purpose: expose the cause code.
    always_comb rst_cause = cause_q;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Checker for pwr_mode_ctrl: port-level temporal properties, bound to the
// top module. Assumes the same parameters as the bound instance.
module pwr_mode_ctrl_chk #(
    parameter int              NIRQ          = 8,
    parameter int              NBANK         = 2,
    parameter int              RST_CYC       = 4,
    parameter logic [NIRQ-1:0] SLP_WAKE_MASK = 8'h0F
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [NIRQ-1:0]  irq_pend,
    input logic [NIRQ-1:0]  irq_en,
    input logic             wake_pin_n,
    input logic             wdt_rst,
    input logic [1:0]       mode_rd,
    input logic             core_clk_en,
    input logic             core_rst,
    input logic             periph_on,
    input logic             iram_on,
    input logic [NBANK-1:0] bank_on,
    input logic [1:0]       rst_cause
);

    int hi_cnt;

    // Purpose: length of the current core reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_cnt <= 0;
        else if (core_rst) hi_cnt <= hi_cnt + 1;
        else               hi_cnt <= 0;
    end

    a_r2_stby_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b01 && |(irq_pend & irq_en)) |=> (core_clk_en && !core_rst && mode_rd == 2'b00));

    a_r3_sleep_power: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b10) |-> (iram_on && !periph_on && !core_clk_en));

    a_r4_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b10 && !(|(irq_pend & irq_en & SLP_WAKE_MASK))) |=> (mode_rd == 2'b10));

    a_r5_deep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b11 && !wake_pin_n) |=> (core_rst && rst_cause == 2'b01));

    a_r5_deep_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b11) |-> (!core_clk_en && !periph_on && !iram_on && bank_on == '0));

    a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_rst && hi_cnt != 0) |-> (hi_cnt == RST_CYC));

    a_r7_cause_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rst_cause) |-> $rose(core_rst));

    a_r8_wdt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b00 && !core_rst && wdt_rst && mode_wr) |=> (core_rst && rst_cause == 2'b10));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
    .NIRQ          (NIRQ),
    .NBANK         (NBANK),
    .RST_CYC       (RST_CYC),
    .SLP_WAKE_MASK (SLP_WAKE_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .wake_pin_n  (wake_pin_n),
    .wdt_rst     (wdt_rst),
    .mode_rd     (mode_rd),
    .core_clk_en (core_clk_en),
    .core_rst    (core_rst),
    .periph_on   (periph_on),
    .iram_on     (iram_on),
    .bank_on     (bank_on),
    .rst_cause   (rst_cause)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          NIRQ       = 8;
    localparam int          NBANK      = 2;
    localparam int          RST_CYC    = 4;
    localparam logic [7:0]  WMASK      = 8'h0F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [1:0]       mode_wdata = 2'b00;
    logic [NBANK-1:0] bank_keep = '0;
    logic [NIRQ-1:0]  irq_pend = '0;
    logic [NIRQ-1:0]  irq_en = '0;
    logic             wake_pin_n = 1'b1;
    logic             wdt_rst = 1'b0;
    logic             sw_rst = 1'b0;
    logic [1:0]       mode_rd;
    logic             core_clk_en, core_rst, periph_on, iram_on;
    logic [NBANK-1:0] bank_on;
    logic [1:0]       rst_cause;

    int checks = 0;
    int failures = 0;

    // reference model: 0 run, 1 standby, 2 sleep, 3 deep sleep, 4 core reset
    int         m_state = 4;
    int         m_cnt = 0;
    int         m_cause = 0;
    logic [1:0] m_keep = 2'b11;

    pwr_mode_ctrl #(
        .NIRQ(NIRQ), .NBANK(NBANK), .RST_CYC(RST_CYC), .SLP_WAKE_MASK(WMASK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .bank_keep(bank_keep), .irq_pend(irq_pend), .irq_en(irq_en),
        .wake_pin_n(wake_pin_n), .wdt_rst(wdt_rst), .sw_rst(sw_rst),
        .mode_rd(mode_rd), .core_clk_en(core_clk_en), .core_rst(core_rst),
        .periph_on(periph_on), .iram_on(iram_on), .bank_on(bank_on),
        .rst_cause(rst_cause)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // model update at each active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 4; m_cnt = 0; m_cause = 0; m_keep = 2'b11;
        end else begin
            case (m_state)
                0: begin
                    if (wdt_rst) begin m_state = 4; m_cnt = 0; m_cause = 2; end
                    else if (sw_rst) begin m_state = 4; m_cnt = 0; m_cause = 3; end
                    else if (mode_wr) begin m_keep = bank_keep; m_state = int'(mode_wdata); end
                end
                1: if ((irq_pend & irq_en) != 0) m_state = 0;
                2: if ((irq_pend & irq_en & WMASK) != 0) begin m_state = 4; m_cnt = 0; m_cause = 1; end
                3: if (!wake_pin_n) begin m_state = 4; m_cnt = 0; m_cause = 1; end
                default: begin
                    if (m_cnt == RST_CYC - 1) begin m_state = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            int  e_mode;
            bit  e_clk, e_rst, e_per, e_iram;
            logic [1:0] e_bank;
            string tag;
            e_mode = (m_state == 4) ? 0 : m_state;
            e_clk  = (m_state == 0 || m_state == 4);
            e_rst  = (m_state == 4);
            e_per  = (m_state == 0 || m_state == 1 || m_state == 4);
            e_iram = (m_state != 3);
            e_bank = (m_state == 2) ? m_keep : ((m_state == 3) ? 2'b00 : 2'b11);
            case (m_state)
                0: tag = "R1";
                1: tag = "R2";
                2: tag = "R3";
                3: tag = "R5";
                default: tag = "R6";
            endcase
            chk(int'(mode_rd) == e_mode, {tag, " mode_rd"}, int'(mode_rd), e_mode);
            chk({core_clk_en, core_rst, periph_on, iram_on} == {e_clk, e_rst, e_per, e_iram},
                {tag, " enables"}, int'({core_clk_en, core_rst, periph_on, iram_on}),
                int'({e_clk, e_rst, e_per, e_iram}));
            chk(bank_on == e_bank, {tag, " bank_on"}, int'(bank_on), int'(e_bank));
            chk(int'(rst_cause) == m_cause, "R7 rst_cause", int'(rst_cause), m_cause);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] m, input logic [1:0] k);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m; bank_keep = k;
        @(negedge clk);
        mode_wr = 1'b0; bank_keep = 2'b00;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R10: power-on pulse with cause 00
        chk(core_rst == 1'b1, "R10 core_rst after release", int'(core_rst), 1);
        cyc(RST_CYC - 1);
        chk(core_rst == 1'b1, "R10 last pulse cycle", int'(core_rst), 1);
        cyc(1);
        chk(core_rst == 1'b0 && rst_cause == 2'b00, "R10 pulse over", int'({core_rst, rst_cause}), 0);

        // R1: write of 00 stays running
        write_mode(2'b00, 2'b00);
        chk(mode_rd == 2'b00 && core_clk_en, "R1 write 00", int'(mode_rd), 0);

        // R2: standby, disabled interrupt ignored, then enabled one resumes
        write_mode(2'b01, 2'b00);
        chk(mode_rd == 2'b01, "R2 enter standby", int'(mode_rd), 1);
        irq_pend = 8'h80; cyc(3);
        chk(mode_rd == 2'b01, "R2 disabled irq", int'(mode_rd), 1);
        // R9: watchdog and writes ignored in standby
        wdt_rst = 1'b1; mode_wr = 1'b1; mode_wdata = 2'b11; cyc(1);
        wdt_rst = 1'b0; mode_wr = 1'b0;
        chk(mode_rd == 2'b01 && !core_rst, "R9 ignored in standby", int'(mode_rd), 1);
        irq_en = 8'h80; cyc(1);
        chk(mode_rd == 2'b00 && !core_rst, "R2 resume no reset", int'({mode_rd, core_rst}), 0);
        irq_pend = '0; irq_en = '0;

        // R3/R4: sleep keeping bank 1 only
        write_mode(2'b10, 2'b10);
        chk(bank_on == 2'b10 && iram_on && !periph_on, "R3 sleep keep 10", int'(bank_on), 2);
        irq_pend = 8'h20; irq_en = 8'h20; cyc(3);
        chk(mode_rd == 2'b10, "R4 irq outside mask", int'(mode_rd), 2);
        irq_pend = 8'h24; irq_en = 8'h24; cyc(1);
        chk(core_rst && rst_cause == 2'b01, "R6 sleep wake reset", int'({core_rst, rst_cause}), 5);
        irq_pend = '0; irq_en = '0;
        // R9: write during reset pulse ignored
        mode_wr = 1'b1; mode_wdata = 2'b01; cyc(1); mode_wr = 1'b0;
        cyc(RST_CYC);
        chk(mode_rd == 2'b00 && !core_rst, "R9 write in reset ignored", int'(mode_rd), 0);

        // R3: other bank choice
        write_mode(2'b10, 2'b01);
        chk(bank_on == 2'b01, "R3 sleep keep 01", int'(bank_on), 1);
        irq_pend = 8'h01; irq_en = 8'h01; cyc(1);
        irq_pend = '0; irq_en = '0;
        cyc(RST_CYC + 1);

        // R5: deep sleep ignores interrupts, wakes on pin
        write_mode(2'b11, 2'b11);
        chk(bank_on == 2'b00 && !iram_on, "R5 deep all off", int'({bank_on, iram_on}), 0);
        irq_pend = 8'hFF; irq_en = 8'hFF; cyc(3);
        chk(mode_rd == 2'b11, "R5 irq ignored", int'(mode_rd), 3);
        irq_pend = '0; irq_en = '0;
        wake_pin_n = 1'b0; cyc(1); wake_pin_n = 1'b1;
        chk(core_rst && rst_cause == 2'b01, "R5 pin wake", int'({core_rst, rst_cause}), 5);
        cyc(RST_CYC);

        // R8: watchdog + software + write in one cycle
        wdt_rst = 1'b1; sw_rst = 1'b1; mode_wr = 1'b1; mode_wdata = 2'b10; cyc(1);
        wdt_rst = 1'b0; sw_rst = 1'b0; mode_wr = 1'b0;
        chk(core_rst && rst_cause == 2'b10, "R8 watchdog wins", int'({core_rst, rst_cause}), 6);
        cyc(RST_CYC);
        chk(mode_rd == 2'b00 && !core_rst, "R8 no mode change", int'(mode_rd), 0);
        sw_rst = 1'b1; mode_wr = 1'b1; mode_wdata = 2'b01; cyc(1);
        sw_rst = 1'b0; mode_wr = 1'b0;
        chk(core_rst && rst_cause == 2'b11, "R8 software over write", int'({core_rst, rst_cause}), 7);
        cyc(RST_CYC + 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule